// File: doc/BRIEF.md
# Bus-Synchronized Timed Pulse Injector

This block is a one-shot sequencer that follows activity on a single address line of a target bus. At one precisely timed moment it briefly takes over a data line and pulls it low, forcing one bit of a word in flight to zero. Each arm request starts one sequence:

1. Align to the target's startup state. How it aligns depends on whether the address line is high or low when arm arrives.
2. Wait a long coarse boot offset. This lands in a quiet gap of the address traffic.
3. Lock onto a trigger taken from the address line. The trigger is either its next rising edge or the falling edge of its Nth pulse.
4. Wait a fine bit offset.
5. Enable the data-line driver for a short override width.
6. Release the line and hold a done flag.

All delays are parameters given in nanoseconds. They are turned into clock cycles from a parameterized clock frequency. The address input crosses into the clock domain through a two-flop synchronizer. A status LED output shows that the coarse offset has expired.

Top module: `bus_pulse_injector`

## Requirements
- R1: While `rstN` is low, `dataOe`, `ledOn` and `done` are 0. `dataOe` drops at once when reset asserts, without waiting for a clock edge.
- R2: If the synchronized address level is high in the cycle arm is taken, the block first waits for a falling edge. It then waits for the following rising edge, and only that rising edge starts the boot offset.
- R3: If the synchronized address level is low in the cycle arm is taken, the next rising edge starts the boot offset.
- R4: The boot offset lasts BOOT_NS converted to cycles, counted from the clock edge that acts on the alignment edge. `ledOn` rises on the clock edge where the offset expires. It stays high until the next arm or reset.
- R5: In edge mode (PULSE_MODE = 0), the first rising edge of the address line after the boot offset is the trigger.
- R6: In pulse-count mode (PULSE_MODE = 1), rising edges are counted after the boot offset. The trigger is the falling edge that ends the PULSE_N-th pulse.
- R7: After the trigger, the block waits exactly BIT_NS converted to cycles. Then `dataOe` rises.
- R8: `dataOe` stays high for exactly DRIVE_NS converted to cycles, once per arm. `dataOut` is 0 whenever `dataOe` is high, so the line is pulled low.
- R9: After the override, `done` rises and holds. Address activity after that, and arm pulses taken while a sequence is running, have no effect on any output.
- R10: Arm taken while `done` is high clears `done` and `ledOn` and starts a new sequence.
- R11: The address pin passes through two flops before edge detection. An edge applied after clock edge c is acted on at clock edge c+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Starts one sequence when idle or done |
| addrIn | input | 1 | Monitored address line of the target bus (asynchronous) |
| dataOe | output | 1 | Output enable of the data-line driver; high only in the override window |
| dataOut | output | 1 | Value driven onto the data line while enabled (always 0) |
| ledOn | output | 1 | Status light, high once the boot offset has expired |
| done | output | 1 | Sequence finished; held until re-arm or reset |

## Verification
The bench builds two instances at 125 MHz, one in edge mode and one in pulse-count mode with PULSE_N = 3. Both use BOOT_NS = 800, BIT_NS = 240 and DRIVE_NS = 40, which give 100, 30 and 5 cycles. These short windows let a whole sequence, including both alignment branches, fit in a few hundred cycles. That leaves room for several runs: a re-arm from done, an arm pulse during the boot offset, traffic after done, and a reset in the middle of the override. A behavioural model of each mode is compared with the outputs on every clock. Explicit latency checks measure the boot, trigger and fine windows from the edges the bench applies.

// File: rtl/inj_pkg.sv
package inj_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN_FALL,
    ST_ALIGN_RISE,
    ST_BOOT,
    ST_TRIG,
    ST_FINE,
    ST_DRIVE,
    ST_DONE
  } injState_t;

  typedef struct packed {
    logic loadBoot;
    logic loadFine;
    logic loadDrive;
    logic trigWin;
  } injStrobe_t;

  function automatic longint nsToCycles(input longint hz, input longint ns);
    longint c;
    c = (hz * ns) / 64'd1_000_000_000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic longint maxOf3(input longint a, input longint b, input longint c);
    longint m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/inj_datapath.sv
module inj_datapath
  import inj_pkg::*;
#(
  parameter int     CLK_HZ     = 125_000_000,
  parameter longint BOOT_NS    = 83_900_000,
  parameter longint BIT_NS     = 225_600,
  parameter longint DRIVE_NS   = 200,
  parameter bit     PULSE_MODE = 1'b0,
  parameter int     PULSE_N    = 47
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrIn,
  input  injStrobe_t strobe,
  output logic       addrLvl,
  output logic       riseDet,
  output logic       fallDet,
  output logic       timerZero,
  output logic       trigHit
);

  localparam longint BOOT_CYC  = nsToCycles(longint'(CLK_HZ), BOOT_NS);
  localparam longint FINE_CYC  = nsToCycles(longint'(CLK_HZ), BIT_NS);
  localparam longint DRIVE_CYC = nsToCycles(longint'(CLK_HZ), DRIVE_NS);
  localparam int     TMR_W     = $clog2(maxOf3(BOOT_CYC, FINE_CYC, DRIVE_CYC) + 1);
  localparam logic [TMR_W-1:0] BOOT_LD  = TMR_W'(BOOT_CYC - 1);
  localparam logic [TMR_W-1:0] FINE_LD  = TMR_W'(FINE_CYC - 1);
  localparam logic [TMR_W-1:0] DRIVE_LD = TMR_W'(DRIVE_CYC - 1);

  logic syncA, syncB, prevB;
  logic [TMR_W-1:0] timer;

  // two-flop synchronizer followed by an edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= addrIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign addrLvl = syncB;
  assign riseDet = syncB & ~prevB;
  assign fallDet = ~syncB & prevB;

  // shared down-counter for the boot, fine and drive windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.loadBoot) begin
      timer <= BOOT_LD;
    end else if (strobe.loadFine) begin
      timer <= FINE_LD;
    end else if (strobe.loadDrive) begin
      timer <= DRIVE_LD;
    end else if (timer != '0) begin
      timer <= timer - TMR_W'(1);
    end
  end

  assign timerZero = (timer == '0);

  AST_FINE_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadFine) |-> (timer == FINE_LD)) else $error("fine load"); // R7

  generate
    if (PULSE_MODE) begin : gPulse
      localparam int CNT_W = $clog2(PULSE_N + 1);
      logic [CNT_W-1:0] pulseCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pulseCnt <= '0;
        end else if (!strobe.trigWin) begin
          pulseCnt <= '0;
        end else if (riseDet) begin
          pulseCnt <= pulseCnt + CNT_W'(1);
        end
      end

      assign trigHit = strobe.trigWin & fallDet & (pulseCnt == CNT_W'(PULSE_N));

      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
        pulseCnt <= CNT_W'(PULSE_N)) else $error("pulse count overflow"); // R6
    end else begin : gEdge
      assign trigHit = strobe.trigWin & riseDet;
    end
  endgenerate

endmodule

// File: rtl/inj_control.sv
module inj_control
  import inj_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       arm,
  input  logic       addrLvl,
  input  logic       riseDet,
  input  logic       fallDet,
  input  logic       timerZero,
  input  logic       trigHit,
  output injStrobe_t strobe,
  output logic       oeQ,
  output logic       ledQ,
  output logic       doneQ
);

  injState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (arm) stateD = addrLvl ? ST_ALIGN_FALL : ST_ALIGN_RISE;
      end
      ST_ALIGN_FALL: begin
        if (fallDet) stateD = ST_ALIGN_RISE;
      end
      ST_ALIGN_RISE: begin
        if (riseDet) begin
          stateD = ST_BOOT;
          strobe.loadBoot = 1'b1;
        end
      end
      ST_BOOT: begin
        if (timerZero) stateD = ST_TRIG;
      end
      ST_TRIG: begin
        strobe.trigWin = 1'b1;
        if (trigHit) begin
          stateD = ST_FINE;
          strobe.loadFine = 1'b1;
        end
      end
      ST_FINE: begin
        if (timerZero) begin
          stateD = ST_DRIVE;
          strobe.loadDrive = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (timerZero) stateD = ST_DONE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      oeQ    <= 1'b0;
      ledQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      oeQ    <= (stateD == ST_DRIVE);
      ledQ   <= (stateD == ST_TRIG) || (stateD == ST_FINE) ||
                (stateD == ST_DRIVE) || (stateD == ST_DONE);
      doneQ  <= (stateD == ST_DONE);
    end
  end

  AST_BOOT_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BOOT && $past(stateQ) != ST_BOOT) |-> $past(riseDet)) else $error("boot entry"); // R3
  AST_LED_AT_BOOT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ledQ) |-> ($past(stateQ) == ST_BOOT && $past(timerZero))) else $error("led rise"); // R4
  AST_OE_AFTER_FINE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeQ) |-> ($past(stateQ) == ST_FINE)) else $error("oe rise"); // R7
  AST_DONE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> ($past(stateQ) == ST_DRIVE)) else $error("done rise"); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !arm) |=> doneQ) else $error("done dropped"); // R9

endmodule

// File: rtl/bus_pulse_injector.sv
module bus_pulse_injector
  import inj_pkg::*;
#(
  parameter int     CLK_HZ     = 125_000_000,
  parameter longint BOOT_NS    = 83_900_000,
  parameter longint BIT_NS     = 225_600,
  parameter longint DRIVE_NS   = 200,
  parameter bit     PULSE_MODE = 1'b0,
  parameter int     PULSE_N    = 47
) (
  input  logic clk,
  input  logic rstN,
  input  logic arm,
  input  logic addrIn,
  output logic dataOe,
  output logic dataOut,
  output logic ledOn,
  output logic done
);

  injStrobe_t strobe;
  logic addrLvl, riseDet, fallDet, timerZero, trigHit;

  inj_datapath #(
    .CLK_HZ(CLK_HZ), .BOOT_NS(BOOT_NS), .BIT_NS(BIT_NS), .DRIVE_NS(DRIVE_NS),
    .PULSE_MODE(PULSE_MODE), .PULSE_N(PULSE_N)
  ) uData (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .strobe(strobe),
    .addrLvl(addrLvl), .riseDet(riseDet), .fallDet(fallDet),
    .timerZero(timerZero), .trigHit(trigHit)
  );

  inj_control uCtrl (
    .clk(clk), .rstN(rstN), .arm(arm), .addrLvl(addrLvl),
    .riseDet(riseDet), .fallDet(fallDet), .timerZero(timerZero),
    .trigHit(trigHit), .strobe(strobe),
    .oeQ(dataOe), .ledQ(ledOn), .doneQ(done)
  );

  // the override only ever pulls the line low
  assign dataOut = 1'b0;

  AST_OE_IN_RESET: assert property (@(posedge clk)
    !rstN |-> (!dataOe && !done && !ledOn)) else $error("outputs in reset"); // R1
  AST_OE_NOT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !done) else $error("oe while done"); // R9

endmodule

// File: tb/tb_bus_pulse_injector.sv
module inj_ref_model #(
  parameter int     CLK_HZ     = 125_000_000,
  parameter longint BOOT_NS    = 800,
  parameter longint BIT_NS     = 240,
  parameter longint DRIVE_NS   = 40,
  parameter bit     PULSE_MODE = 1'b0,
  parameter int     PULSE_N    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic arm,
  input  logic addrIn,
  output logic expOe,
  output logic expLed,
  output logic expDone
);
  function automatic int toCyc(input longint ns);
    longint c;
    c = (longint'(CLK_HZ) * ns) / 1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  // phases: 0 idle, 1 wait fall, 2 wait rise, 3 boot, 4 trigger, 5 fine, 6 drive, 7 done
  int phase, remain, pulses;
  bit hist[$];
  bit lvl, prv, up, dn;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase = 0; remain = 0; pulses = 0;
      hist = {1'b0, 1'b0, 1'b0};
    end else begin
      lvl = hist[1]; prv = hist[2];
      up = lvl && !prv; dn = !lvl && prv;
      hist.push_front(addrIn);
      void'(hist.pop_back());
      case (phase)
        0, 7: if (arm) phase = lvl ? 1 : 2;
        1: if (dn) phase = 2;
        2: if (up) begin phase = 3; remain = toCyc(BOOT_NS); end
        3: begin remain--; if (remain == 0) begin phase = 4; pulses = 0; end end
        4: begin
          if (PULSE_MODE) begin
            if (dn && pulses == PULSE_N) begin phase = 5; remain = toCyc(BIT_NS); end
            if (up) pulses++;
          end else if (up) begin
            phase = 5; remain = toCyc(BIT_NS);
          end
        end
        5: begin remain--; if (remain == 0) begin phase = 6; remain = toCyc(DRIVE_NS); end end
        6: begin remain--; if (remain == 0) phase = 7; end
        default: phase = 0;
      endcase
    end
    expOe   = (phase == 6);
    expLed  = (phase >= 4);
    expDone = (phase == 7);
  end
endmodule

module tb_bus_pulse_injector;
  localparam int     CLK_HZ   = 125_000_000;
  localparam longint BOOT_NS  = 800;
  localparam longint BIT_NS   = 240;
  localparam longint DRIVE_NS = 40;
  localparam int     PN       = 3;
  localparam int     BOOT_C   = 100;
  localparam int     FINE_C   = 30;
  localparam int     DRIVE_C  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arm = 1'b0;
  logic addrIn = 1'b0;
  logic oeA, outA, ledA, doneA, oeB, outB, ledB, doneB;
  logic eOeA, eLedA, eDoneA, eOeB, eLedB, eDoneB;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_pulse_injector #(.CLK_HZ(CLK_HZ), .BOOT_NS(BOOT_NS), .BIT_NS(BIT_NS),
    .DRIVE_NS(DRIVE_NS), .PULSE_MODE(1'b0), .PULSE_N(PN)) dut (
    .clk(clk), .rstN(rstN), .arm(arm), .addrIn(addrIn),
    .dataOe(oeA), .dataOut(outA), .ledOn(ledA), .done(doneA));

  bus_pulse_injector #(.CLK_HZ(CLK_HZ), .BOOT_NS(BOOT_NS), .BIT_NS(BIT_NS),
    .DRIVE_NS(DRIVE_NS), .PULSE_MODE(1'b1), .PULSE_N(PN)) dutCnt (
    .clk(clk), .rstN(rstN), .arm(arm), .addrIn(addrIn),
    .dataOe(oeB), .dataOut(outB), .ledOn(ledB), .done(doneB));

  inj_ref_model #(.CLK_HZ(CLK_HZ), .BOOT_NS(BOOT_NS), .BIT_NS(BIT_NS),
    .DRIVE_NS(DRIVE_NS), .PULSE_MODE(1'b0), .PULSE_N(PN)) refA (
    .clk(clk), .rstN(rstN), .arm(arm), .addrIn(addrIn),
    .expOe(eOeA), .expLed(eLedA), .expDone(eDoneA));

  inj_ref_model #(.CLK_HZ(CLK_HZ), .BOOT_NS(BOOT_NS), .BIT_NS(BIT_NS),
    .DRIVE_NS(DRIVE_NS), .PULSE_MODE(1'b1), .PULSE_N(PN)) refB (
    .clk(clk), .rstN(rstN), .arm(arm), .addrIn(addrIn),
    .expOe(eOeB), .expLed(eLedB), .expDone(eDoneB));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison and event capture
  int oeRiseA, oeRiseB, ledRiseA, oeCntA, oeCntB;
  logic oePrevA = 1'b0, oePrevB = 1'b0, ledPrevA = 1'b0;

  always @(negedge clk) begin
    check(oeA == eOeA, "R8 edge-mode dataOe", oeA, eOeA);
    check(ledA == eLedA, "R4 edge-mode ledOn", ledA, eLedA);
    check(doneA == eDoneA, "R9 edge-mode done", doneA, eDoneA);
    check(oeB == eOeB, "R6 count-mode dataOe", oeB, eOeB);
    check(ledB == eLedB, "R4 count-mode ledOn", ledB, eLedB);
    check(doneB == eDoneB, "R9 count-mode done", doneB, eDoneB);
    if (oeA || oeB) check(!outA && !outB, "R8 drive value low", int'(outA | outB), 0);
    if (oeA && !oePrevA) oeRiseA = cyc;
    if (oeB && !oePrevB) oeRiseB = cyc;
    if (ledA && !ledPrevA) ledRiseA = cyc;
    if (oeA) oeCntA++;
    if (oeB) oeCntB++;
    oePrevA = oeA; oePrevB = oeB; ledPrevA = ledA;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseArm();
    arm = 1'b1; tick(1); arm = 1'b0;
  endtask

  int alignCyc, firstRiseCyc, nthFallCyc;

  task automatic doRun(input bit startHigh, input bit armMid);
    oeCntA = 0; oeCntB = 0;
    if (startHigh) begin
      addrIn = 1'b1; tick(4);
      pulseArm(); tick(6);
      addrIn = 1'b0; tick(6);
    end else begin
      pulseArm(); tick(6);
    end
    addrIn = 1'b1; alignCyc = cyc; tick(4);
    addrIn = 1'b0; tick(4);
    if (armMid) begin
      tick(40); pulseArm(); tick(BOOT_C + 20 - 41);
    end else begin
      tick(BOOT_C + 20);
    end
    for (int i = 0; i < 6; i++) begin
      addrIn = 1'b1;
      if (i == 0) firstRiseCyc = cyc;
      tick(3);
      addrIn = 1'b0;
      if (i == PN - 1) nthFallCyc = cyc;
      tick(3);
    end
    tick(FINE_C + DRIVE_C + 10);
  endtask

  task automatic runChecks(input string alignTag);
    check(ledRiseA == alignCyc + 3 + BOOT_C, alignTag, ledRiseA, alignCyc + 3 + BOOT_C);
    check(oeRiseA == firstRiseCyc + 3 + FINE_C, "R5 R11 edge trigger to dataOe",
          oeRiseA, firstRiseCyc + 3 + FINE_C);
    check(oeRiseB == nthFallCyc + 3 + FINE_C, "R6 R7 Nth fall to dataOe",
          oeRiseB, nthFallCyc + 3 + FINE_C);
    check(oeCntA == DRIVE_C, "R8 edge-mode override width", oeCntA, DRIVE_C);
    check(oeCntB == DRIVE_C, "R8 count-mode override width", oeCntB, DRIVE_C);
    check(doneA && doneB, "R9 done after run", int'(doneA & doneB), 1);
  endtask

  initial begin
    tick(3);
    check(!oeA && !ledA && !doneA && !oeB && !ledB && !doneB, "R1 outputs in reset",
          int'(oeA | ledA | doneA | oeB | ledB | doneB), 0);
    rstN = 1'b1;
    tick(2);
    // traffic with no arm: nothing starts
    for (int i = 0; i < 4; i++) begin addrIn = 1'b1; tick(3); addrIn = 1'b0; tick(3); end
    check(!oeA && !ledA && !ledB, "R9 idle ignores traffic", int'(oeA | ledA | ledB), 0);

    doRun(1'b0, 1'b0);
    runChecks("R3 low-start boot offset");

    // activity after done is ignored
    oeCntA = 0; oeCntB = 0;
    for (int i = 0; i < 5; i++) begin addrIn = 1'b1; tick(3); addrIn = 1'b0; tick(3); end
    tick(FINE_C + 10);
    check(oeCntA == 0 && oeCntB == 0, "R9 no override after done", oeCntA + oeCntB, 0);
    check(doneA && doneB, "R9 done held", int'(doneA & doneB), 1);

    // re-arm with the line high at arm time
    addrIn = 1'b1; tick(4);
    pulseArm(); tick(3);
    check(!doneA && !ledA && !doneB, "R10 re-arm clears done and led",
          int'(doneA | ledA | doneB), 0);
    tick(12);
    check(!ledA, "R2 high level alone does not start boot", int'(ledA), 0);
    addrIn = 1'b0; tick(6);
    oeCntA = 0; oeCntB = 0;
    addrIn = 1'b1; alignCyc = cyc; tick(4);
    addrIn = 1'b0; tick(BOOT_C + 24);
    for (int i = 0; i < 6; i++) begin
      addrIn = 1'b1;
      if (i == 0) firstRiseCyc = cyc;
      tick(3);
      addrIn = 1'b0;
      if (i == PN - 1) nthFallCyc = cyc;
      tick(3);
    end
    tick(FINE_C + DRIVE_C + 10);
    runChecks("R2 high-start boot offset");

    // arm pulse in the middle of the boot offset is ignored
    doRun(1'b0, 1'b1);
    runChecks("R9 R4 arm during boot ignored");

    // reset in the middle of the override
    pulseArm(); tick(6);
    addrIn = 1'b1; tick(4); addrIn = 1'b0; tick(BOOT_C + 20);
    addrIn = 1'b1; tick(3 + FINE_C + 2);
    check(oeA == 1'b1, "R8 override active before reset", int'(oeA), 1);
    #1 rstN = 1'b0;
    #1 check(!oeA && !oeB, "R1 reset drops dataOe at once", int'(oeA | oeB), 0);
    addrIn = 1'b0;
    tick(3);
    check(!ledA && !doneA, "R1 led and done cleared by reset", int'(ledA | doneA), 0);
    rstN = 1'b1;
    tick(5);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150_000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule